// File: doc/BRIEF.md
# Parallel ATA Programmed-I/O Port Window Adapter

This block lets a host reach application I/O ports through the programmed-I/O register file of a parallel ATA channel. It samples the host strobes, the three address lines and the two active-low chip selects on its own clock. It reacts only to a small set of task-file addresses that the ATA standard lets a host read and write freely, with no side effects. Write data goes to an internal write bus as a one-cycle enable with a window index. Read data comes from the application through a synchronisation register and is driven back onto the ATA data bus, with a separate output enable. There is no internal tristate bus.

The device/head register is used as a port selector. The block keeps a private copy of every host write to it. Bits 3..0 of that copy name the active application port, and bit 4 must match the device position the block is built for. The block writes nothing and drives nothing unless the copy holds a non-zero port code that this instance owns. BIOS probing therefore never sees it. Several instances with disjoint sets of owned codes can share one channel. The device/head register is never read back: a host read of it is left undriven, so the bus floats to FFh.

Top module: `pata_port_window`

## Requirements
- R1: After reset, `dd_oe` is 0, `app_wr_en` is 0 and `app_port_ok` is 0.
- R2: A host write with chip select 0 low, chip select 1 high and address 6 loads the selector copy. `app_port` equals data bits 3..0. `app_port_ok` is 1 exactly when data bit 4 equals DEV_SEL (default 1) and the code is owned (default codes 1 to 7). Bits 7..5 have no effect.
- R3: A host read of the selector address (chip select 0 low, chip select 1 high, address 6) never asserts `dd_oe`, whatever the port state.
- R4: With `app_port_ok` at 1, a host write with chip select 0 low, chip select 1 high and address 2 to 5 gives exactly one `app_wr_en` pulse of one cycle after the write strobe ends. `app_wr_win` is the address minus 2, and `app_wr_data` is the bus data.
- R5: With `app_port_ok` at 0, a write to a window address gives no `app_wr_en` pulse.
- R6: Every other chip select and address combination gives no write pulse and no drive. That covers chip select 1 low, both selects low, both high, and addresses 0, 1 and 7, including the command register.
- R7: With `app_port_ok` at 1 and the read strobe held low on a window address, `dd_oe` is 1. From the third clock of the strobe on, `dd_out` equals byte (address minus 2) of `app_rd_bus`, where byte k occupies bits 8k+7..8k.
- R8: `dd_oe` is 0 whenever the read strobe is high, within the same cycle it rises, and it is 0 for any read while `app_port_ok` is 0.
- R9: A port code of 0 never gives `app_port_ok`, even with bit 4 matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_cs0_n | input | 1 | Command-block chip select, active low |
| host_cs1_n | input | 1 | Control-block chip select, active low |
| host_addr | input | 3 | Register address lines |
| dd_in | input | 8 | ATA data bus, input side |
| dd_out | output | 8 | ATA data bus, output side (read synchronisation register) |
| dd_oe | output | 1 | Output enable for the ATA data bus |
| app_port | output | 4 | Port code held in the selector copy |
| app_port_ok | output | 1 | Selected port is valid and owned by this instance |
| app_wr_en | output | 1 | One-cycle write enable toward the application |
| app_wr_win | output | 2 | Window index of the write |
| app_wr_data | output | 8 | Write data toward the application |
| app_rd_bus | input | 32 | Read inputs of the selected port, one byte per window |

## Verification
The bench sweeps 32 selector values. These cover every port code with both device-select values, and the upper bits alternate. For each one it tries all 32 combinations of the two chip selects and three address lines, as a write and as a read. The selector sweep separates owned, unowned and zero codes and the wrong device position, and shows that bits 7..5 have no effect. The address sweep separates the four windows from the selector, command, data and control-block addresses. The per-access data patterns differ for every window, so a wrong window index or a wrong byte lane shows up as a data mismatch.

// File: rtl/pata_win_pkg.sv
package pata_win_pkg;
   typedef struct packed {
      logic       rd_n;
      logic       wr_n;
      logic       cs0_n;
      logic       cs1_n;
      logic [2:0] addr;
   } hsamp_t;

   localparam int unsigned PORT_W = 4;
endpackage

// File: rtl/pata_host_sampler.sv
module pata_host_sampler
   import pata_win_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  hsamp_t        pin,
   input  logic [DW-1:0] pin_data,
   output hsamp_t        cur,
   output hsamp_t        prv,
   output logic [DW-1:0] prv_data
);
   localparam hsamp_t IDLE = '{rd_n: 1'b1, wr_n: 1'b1, cs0_n: 1'b1, cs1_n: 1'b1, addr: 3'd0};
   logic [DW-1:0] cur_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur      <= IDLE;
         prv      <= IDLE;
         cur_data <= '0;
         prv_data <= '0;
      end else begin
         cur      <= pin;
         prv      <= cur;
         cur_data <= pin_data;
         prv_data <= cur_data;
      end
   end
endmodule

// File: rtl/pata_reg_decode.sv
module pata_reg_decode #(
   parameter int unsigned NWIN     = 4,
   parameter int unsigned WIN_BASE = 2,
   parameter int unsigned SEL_ADDR = 6,
   localparam int unsigned WIDX    = $clog2(NWIN)
) (
   input  logic            cs0_n,
   input  logic            cs1_n,
   input  logic [2:0]      addr,
   output logic            hit_sel,
   output logic            hit_win,
   output logic [WIDX-1:0] win_idx
);
   logic            blk_ok;
   logic [NWIN-1:0] match;

   assign blk_ok = !cs0_n && cs1_n;

   for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
      assign match[gi] = (addr == 3'(WIN_BASE + gi));
   end

   always_comb begin
      win_idx = '0;
      for (int i = 0; i < NWIN; i++) begin
         if (match[i]) win_idx = WIDX'(i);
      end
   end

   assign hit_win = blk_ok && (|match);
   assign hit_sel = blk_ok && (addr == 3'(SEL_ADDR));
endmodule

// File: rtl/pata_port_select.sv
module pata_port_select
   import pata_win_pkg::*;
#(
   parameter logic [15:0] OWN_MASK = 16'h00FE,
   parameter bit          DEV_SEL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [4:0]        din,
   output logic [PORT_W-1:0] port,
   output logic              ok
);
   localparam logic [15:0] MASK_EFF = OWN_MASK & 16'hFFFE;

   logic       dev_bit;
   logic [3:0] code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_bit <= ~DEV_SEL;
         code    <= '0;
      end else if (load) begin
         dev_bit <= din[4];
         code    <= din[3:0];
      end
   end

   assign port = code;
   assign ok   = (dev_bit == DEV_SEL) && MASK_EFF[code];
endmodule

// File: rtl/pata_read_path.sv
module pata_read_path #(
   parameter int unsigned DW   = 8,
   parameter int unsigned NWIN = 4,
   localparam int unsigned WIDX = $clog2(NWIN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDX-1:0]  idx,
   input  logic [NWIN*DW-1:0] rd_bus,
   output logic [DW-1:0]    dout
);
   logic [DW-1:0] sel;
   assign sel = rd_bus[idx*DW +: DW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dout <= '0;
      else if (load) dout <= sel;
   end
endmodule

// File: rtl/pata_port_window.sv
module pata_port_window
   import pata_win_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned NWIN     = 4,
   parameter int unsigned WIN_BASE = 2,
   parameter int unsigned SEL_ADDR = 6,
   parameter bit          DEV_SEL  = 1'b1,
   parameter logic [15:0] OWN_MASK = 16'h00FE,
   localparam int unsigned WIDX    = $clog2(NWIN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_rd_n,
   input  logic               host_wr_n,
   input  logic               host_cs0_n,
   input  logic               host_cs1_n,
   input  logic [2:0]         host_addr,
   input  logic [DW-1:0]      dd_in,
   output logic [DW-1:0]      dd_out,
   output logic               dd_oe,
   output logic [PORT_W-1:0]  app_port,
   output logic               app_port_ok,
   output logic               app_wr_en,
   output logic [WIDX-1:0]    app_wr_win,
   output logic [DW-1:0]      app_wr_data,
   input  logic [NWIN*DW-1:0] app_rd_bus
);
   if (DW < 5) begin : g_dw_chk
      $error("DW must hold device/head bits 4..0");
   end
   if (NWIN < 2 || WIN_BASE + NWIN > SEL_ADDR) begin : g_win_chk
      $error("window range must be at least two wide and end below the selector address");
   end

   hsamp_t        pin, cur, prv;
   logic [DW-1:0] prv_data;

   assign pin = '{rd_n: host_rd_n, wr_n: host_wr_n, cs0_n: host_cs0_n,
                  cs1_n: host_cs1_n, addr: host_addr};

   pata_host_sampler #(.DW(DW)) u_samp (
      .clk(clk), .rst_n(rst_n), .pin(pin), .pin_data(dd_in),
      .cur(cur), .prv(prv), .prv_data(prv_data));

   logic            w_sel, w_win, r_sel, r_win, p_sel, p_win;
   logic [WIDX-1:0] w_idx, r_idx, p_idx;

   pata_reg_decode #(.NWIN(NWIN), .WIN_BASE(WIN_BASE), .SEL_ADDR(SEL_ADDR)) u_dec_wr (
      .cs0_n(prv.cs0_n), .cs1_n(prv.cs1_n), .addr(prv.addr),
      .hit_sel(w_sel), .hit_win(w_win), .win_idx(w_idx));

   pata_reg_decode #(.NWIN(NWIN), .WIN_BASE(WIN_BASE), .SEL_ADDR(SEL_ADDR)) u_dec_rd (
      .cs0_n(cur.cs0_n), .cs1_n(cur.cs1_n), .addr(cur.addr),
      .hit_sel(r_sel), .hit_win(r_win), .win_idx(r_idx));

   pata_reg_decode #(.NWIN(NWIN), .WIN_BASE(WIN_BASE), .SEL_ADDR(SEL_ADDR)) u_dec_pin (
      .cs0_n(host_cs0_n), .cs1_n(host_cs1_n), .addr(host_addr),
      .hit_sel(p_sel), .hit_win(p_win), .win_idx(p_idx));

   // write strobe end: low in the previous sample, high in the current one
   logic wr_end, sel_load, win_wr;
   assign wr_end   = !prv.wr_n && cur.wr_n;
   assign sel_load = wr_end && w_sel;
   assign win_wr   = wr_end && w_win && app_port_ok;

   pata_port_select #(.OWN_MASK(OWN_MASK), .DEV_SEL(DEV_SEL)) u_port (
      .clk(clk), .rst_n(rst_n), .load(sel_load), .din(prv_data[4:0]),
      .port(app_port), .ok(app_port_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         app_wr_en   <= 1'b0;
         app_wr_win  <= '0;
         app_wr_data <= '0;
      end else begin
         app_wr_en <= win_wr;
         if (win_wr) begin
            app_wr_win  <= w_idx;
            app_wr_data <= prv_data;
         end
      end
   end

   logic rd_load;
   assign rd_load = !cur.rd_n && r_win && app_port_ok;

   pata_read_path #(.DW(DW), .NWIN(NWIN)) u_rd (
      .clk(clk), .rst_n(rst_n), .load(rd_load), .idx(r_idx),
      .rd_bus(app_rd_bus), .dout(dd_out));

   assign dd_oe = !host_rd_n && p_win && app_port_ok;

   // R8
   oe_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dd_oe |-> app_port_ok);
   // R3
   dh_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_cs0_n && host_cs1_n && host_addr == 3'(SEL_ADDR)) |-> !dd_oe);
   // R4
   wr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      app_wr_en |=> !app_wr_en);
   // R5
   wr_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      app_wr_en |-> app_port_ok);
   // R9
   code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      app_port_ok |-> (app_port != '0));
endmodule

// File: tb/sim_pata_port_window.sv
module sim_pata_port_window;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_rd_n = 1'b1, host_wr_n = 1'b1;
   logic        host_cs0_n = 1'b1, host_cs1_n = 1'b1;
   logic [2:0]  host_addr = '0;
   logic [7:0]  dd_in = '0;
   logic [7:0]  dd_out;
   logic        dd_oe;
   logic [3:0]  app_port;
   logic        app_port_ok;
   logic        app_wr_en;
   logic [1:0]  app_wr_win;
   logic [7:0]  app_wr_data;
   logic [31:0] app_rd_bus = '0;

   int total = 0, bad = 0, pulses = 0;
   logic [1:0] got_win;
   logic [7:0] got_data;

   always #(CLK_P/2) clk = ~clk;

   pata_port_window u0 (.*);

   always @(negedge clk) begin
      if (app_wr_en) begin
         pulses++;
         got_win  = app_wr_win;
         got_data = app_wr_data;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic host_write(input logic c0, input logic c1, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      host_cs0_n = c0; host_cs1_n = c1; host_addr = a; dd_in = d; pulses = 0;
      repeat (2) @(negedge clk);
      host_wr_n = 1'b0;
      repeat (4) @(negedge clk);
      host_wr_n = 1'b1;
      repeat (4) @(negedge clk);
      host_cs0_n = 1'b1; host_cs1_n = 1'b1;
   endtask

   task automatic host_read(input logic c0, input logic c1, input logic [2:0] a,
                            output logic oe, output logic [7:0] dat, output logic oe_after);
      @(negedge clk);
      host_cs0_n = c0; host_cs1_n = c1; host_addr = a;
      repeat (2) @(negedge clk);
      host_rd_n = 1'b0;
      repeat (4) @(negedge clk);
      #1;
      oe = dd_oe; dat = dd_out;
      host_rd_n = 1'b1;
      #1;
      oe_after = dd_oe;
      repeat (2) @(negedge clk);
      host_cs0_n = 1'b1; host_cs1_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 150000);
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic oe, oe_after;
      logic [7:0] dat;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 dd_oe", 32'(dd_oe), 0);
      chk("R1 wr_en", 32'(app_wr_en), 0);
      chk("R1 port_ok", 32'(app_port_ok), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 port_ok after release", 32'(app_port_ok), 0);

      for (int d = 0; d < 32; d++) begin
         logic [7:0] dh;
         logic       exp_ok;
         dh = {((d % 2) != 0) ? 3'b101 : 3'b010, 5'(d)};
         exp_ok = (dh[4] == 1'b1) && (dh[3:0] != 4'd0) && (dh[3:0] <= 4'd7);
         host_write(1'b0, 1'b1, 3'd6, dh);
         chk("R2 port code", 32'(app_port), 32'(dh[3:0]));
         chk(dh[3:0] == 0 ? "R9 zero code" : "R2 port_ok", 32'(app_port_ok), 32'(exp_ok));
         chk("R2 no pulse on selector write", pulses, 0);
         for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 8; a++) begin
               logic c0, c1, is_win, is_sel;
               logic [7:0] wd;
               logic [1:0] ew;
               c0 = c[0]; c1 = c[1];
               is_sel = !c0 && c1 && (a == 6);
               is_win = !c0 && c1 && (a >= 2) && (a <= 5);
               ew = 2'(a - 2);
               if (!is_sel) begin
                  wd = 8'((d * 31 + c * 8 + a) * 7 + 3);
                  host_write(c0, c1, 3'(a), wd);
                  if (is_win && exp_ok) begin
                     chk("R4 one pulse", pulses, 1);
                     chk("R4 window", 32'(got_win), 32'(ew));
                     chk("R4 data", 32'(got_data), 32'(wd));
                  end else if (is_win) begin
                     chk("R5 no pulse for bad port", pulses, 0);
                  end else begin
                     chk("R6 no pulse off window", pulses, 0);
                  end
               end
               app_rd_bus = {8'((d + a) * 13 + 8'h4C), 8'((d + c) * 29 + 8'h91),
                             8'((a + c) * 53 + 8'h27), 8'(d * 7 + a * 3 + 8'hE2)};
               host_read(c0, c1, 3'(a), oe, dat, oe_after);
               chk("R8 oe off after strobe", 32'(oe_after), 0);
               if (is_sel) begin
                  chk("R3 selector read undriven", 32'(oe), 0);
               end else if (is_win && exp_ok) begin
                  chk("R7 oe on", 32'(oe), 1);
                  chk("R7 read data", 32'(dat), 32'(app_rd_bus[ew*8 +: 8]));
               end else if (is_win) begin
                  chk("R8 oe off for bad port", 32'(oe), 0);
               end else begin
                  chk("R6 no drive off window", 32'(oe), 0);
               end
            end
         end
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule